// File: doc/BRIEF.md
# LCD Frame Clock Generator

This block produces the scan timing for a multiplexed LCD panel. Its source clock is either a slow 32.768 kHz clock or the main system clock reduced by a power-of-two prescaler. A second prescaler divides that source down to a reference rate. The reference rate is then split across the common lines that the display duty needs. The outputs are a one-cycle common-advance pulse, the index of the common line being driven, and a frame-start pulse. Waveform drivers and bias generation are not part of this block.

Both clocks arrive as single-cycle enables in the block's own clock domain. An 8-bit configuration register holds the two prescaler selections. Software may rewrite it only while the display, the scan and the bias supply are all switched off. A write attempted at any other time is dropped, and a sticky error flag records it. A combinational flag reports settings whose frame rate, taking the slow clock as the source, would exceed the highest rate allowed.

Top module: `lcd_frame_timer`

## Requirements
- R1: After reset, cfg_rdata is 0x00 and com_adv, com_idx, frame_start and wr_err are all 0.
- R2: A write with lcd_on, scan_on and bias_on all low is stored. cfg_rdata then shows bits 3:0 of the written value, and bits 7:4 read as 0.
- R3: A write made while lcd_on, scan_on or bias_on is high leaves cfg_rdata unchanged. It sets wr_err, which stays at 1 until reset.
- R4: Configuration bits 3:2 select the source tick. Code 00 takes every slow_ce pulse. Codes 01, 10 and 11 take one main_ce pulse in 2^SRC_MIN_LOG2, 2^(SRC_MIN_LOG2+1) and 2^(SRC_MIN_LOG2+2) respectively.
- R5: Configuration bits 1:0 (code k) give one reference tick for every 2^(REF_MIN_LOG2+k) source ticks.
- R6: com_adv is a one-cycle pulse raised once per reference tick. With enables held high and lcd_on rising, the first pulse follows exactly one full reference period.
- R7: com_idx steps by one on each com_adv and wraps to 0 after the last common line. duty_sel 00 gives 1 line (static), 01 gives 3 lines, and 10 or 11 gives 4 lines.
- R8: frame_start pulses together with the com_adv that returns com_idx to 0. In static duty it pulses with every com_adv.
- R9: While lcd_on is low, both prescalers and com_idx are held at zero and no pulses appear. The first reference period after lcd_on rises therefore has full length.
- R10: rate_err is 1 when LOW_HZ / (2^(REF_MIN_LOG2+k) × lines) exceeds MAX_FRAME_HZ. With the defaults this flags static duty with k = 0 or 1, and 3-line duty with k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ce | input | 1 | One pulse per main system clock period |
| slow_ce | input | 1 | One pulse per 32.768 kHz clock period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| lcd_on | input | 1 | Display enable; also runs the prescalers |
| scan_on | input | 1 | Scan enable; blocks writes while high |
| bias_on | input | 1 | Bias supply enable; blocks writes while high |
| duty_sel | input | 2 | Duty: 00 static, 01 three lines, 1x four lines |
| cfg_rdata | output | 8 | Current configuration value |
| com_adv | output | 1 | Common-advance pulse |
| com_idx | output | 2 | Active common line index |
| frame_start | output | 1 | Frame-start pulse |
| rate_err | output | 1 | Selected setting exceeds the frame-rate limit |
| wr_err | output | 1 | Sticky flag for a blocked write |

## Verification
The bench builds the block with SRC_MIN_LOG2 = 2, REF_MIN_LOG2 = 2 and LOW_HZ = 2048. The largest division is then 512 clock cycles, so every pairing of source and reference code, across full four-line frames, fits in a short run. Lowering LOW_HZ by the same factor as REF_MIN_LOG2 keeps the rate-limit truth table identical to the one at the default values. That allows the full rate_err table to be checked directly. A cycle-level model in the bench follows random enable patterns, blocked writes and mid-frame shutdowns.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

   typedef enum logic [1:0] {
      DUTY_STATIC  = 2'b00,
      DUTY_THREE   = 2'b01,
      DUTY_FOUR    = 2'b10,
      DUTY_FOUR_B  = 2'b11
   } duty_e;

   localparam int CFG_W    = 8;
   localparam int CFG_LIVE = 4;

   function automatic logic [2:0] line_count(input logic [1:0] d);
      case (duty_e'(d))
         DUTY_STATIC: line_count = 3'd1;
         DUTY_THREE:  line_count = 3'd3;
         default:     line_count = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/lcd_ft_ctrl.sv
module lcd_ft_ctrl
   import lcd_ft_pkg::*;
#(
   parameter int REF_MIN_LOG2 = 6,
   parameter int LOW_HZ       = 32768,
   parameter int MAX_FRAME_HZ = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             busy,
   input  logic [1:0]       duty_sel,
   output logic [CFG_W-1:0] cfg_q,
   output logic             rate_err,
   output logic             wr_err
);

   logic [CFG_W-1:0] live_mask;
   logic [2:0]       nlines;
   logic [63:0]      limit;

   for (genvar i = 0; i < CFG_W; i++) begin : g_mask
      if (i < CFG_LIVE) begin : g_live
         assign live_mask[i] = 1'b1;
      end else begin : g_fixed
         assign live_mask[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         wr_err <= 1'b0;
      end else if (cfg_we) begin
         if (busy) wr_err <= 1'b1;
         else      cfg_q  <= cfg_wdata & live_mask;
      end
   end

   always_comb begin
      nlines   = line_count(duty_sel);
      limit    = 64'(MAX_FRAME_HZ) * (64'd1 << (REF_MIN_LOG2 + int'(cfg_q[1:0]))) * 64'(nlines);
      rate_err = 64'(LOW_HZ) > limit;
   end

   assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> ($stable(cfg_q) && wr_err));

   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);

   assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !busy) |=> (cfg_q == {4'h0, $past(cfg_wdata[3:0])}));

endmodule

// File: rtl/lcd_ft_prescale.sv
module lcd_ft_prescale #(
   parameter int SRC_MIN_LOG2 = 6,
   parameter int REF_MIN_LOG2 = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       main_ce,
   input  logic       slow_ce,
   input  logic [1:0] src_sel,
   input  logic [1:0] ref_sel,
   output logic       src_tick,
   output logic       ref_tick
);

   localparam int S1W = SRC_MIN_LOG2 + 2;
   localparam int S2W = REF_MIN_LOG2 + 3;

   logic [S1W-1:0] c1, m1;
   logic [S2W-1:0] c2, m2;
   logic           main_tick;

   always_comb begin
      m1        = {S1W{1'b1}} >> (2'd3 - src_sel);
      m2        = {S2W{1'b1}} >> (2'd3 - ref_sel);
      main_tick = run && main_ce && ((c1 & m1) == m1);
      src_tick  = run && ((src_sel == 2'b00) ? slow_ce : main_tick);
      ref_tick  = src_tick && ((c2 & m2) == m2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1 <= '0;
         c2 <= '0;
      end else if (!run) begin
         c1 <= '0;
         c2 <= '0;
      end else begin
         if (main_ce)  c1 <= c1 + 1'b1;
         if (src_tick) c2 <= c2 + 1'b1;
      end
   end

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ref_tick || run);

endmodule

// File: rtl/lcd_ft_seq.sv
module lcd_ft_seq
   import lcd_ft_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       ref_tick,
   input  logic [1:0] duty_sel,
   output logic       com_adv,
   output logic [1:0] com_idx,
   output logic       frame_start
);

   logic [1:0] last;
   logic       at_last;

   always_comb begin
      last    = 2'(line_count(duty_sel) - 3'd1);
      at_last = com_idx >= last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         com_adv     <= 1'b0;
         com_idx     <= '0;
         frame_start <= 1'b0;
      end else if (!run) begin
         com_adv     <= 1'b0;
         com_idx     <= '0;
         frame_start <= 1'b0;
      end else begin
         com_adv     <= ref_tick;
         frame_start <= ref_tick && at_last;
         if (ref_tick) com_idx <= at_last ? 2'd0 : com_idx + 2'd1;
      end
   end

   assert_frame_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (com_adv && com_idx == 2'd0));

   assert_adv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      com_adv |=> !com_adv);

   assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!com_adv && !frame_start && com_idx == 2'd0));

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
   import lcd_ft_pkg::*;
#(
   parameter int SRC_MIN_LOG2 = 6,
   parameter int REF_MIN_LOG2 = 6,
   parameter int LOW_HZ       = 32768,
   parameter int MAX_FRAME_HZ = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       main_ce,
   input  logic       slow_ce,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   input  logic       lcd_on,
   input  logic       scan_on,
   input  logic       bias_on,
   input  logic [1:0] duty_sel,
   output logic [7:0] cfg_rdata,
   output logic       com_adv,
   output logic [1:0] com_idx,
   output logic       frame_start,
   output logic       rate_err,
   output logic       wr_err
);

   initial begin
      assert (SRC_MIN_LOG2 >= 1 && SRC_MIN_LOG2 <= 24) else $error("SRC_MIN_LOG2 out of range");
      assert (REF_MIN_LOG2 >= 1 && REF_MIN_LOG2 <= 24) else $error("REF_MIN_LOG2 out of range");
      assert (LOW_HZ > 0 && MAX_FRAME_HZ > 0) else $error("rates must be positive");
   end

   logic busy, src_tick, ref_tick;

   assign busy = lcd_on | scan_on | bias_on;

   lcd_ft_ctrl #(
      .REF_MIN_LOG2 (REF_MIN_LOG2),
      .LOW_HZ       (LOW_HZ),
      .MAX_FRAME_HZ (MAX_FRAME_HZ)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .busy      (busy),
      .duty_sel  (duty_sel),
      .cfg_q     (cfg_rdata),
      .rate_err  (rate_err),
      .wr_err    (wr_err)
   );

   lcd_ft_prescale #(
      .SRC_MIN_LOG2 (SRC_MIN_LOG2),
      .REF_MIN_LOG2 (REF_MIN_LOG2)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (lcd_on),
      .main_ce  (main_ce),
      .slow_ce  (slow_ce),
      .src_sel  (cfg_rdata[3:2]),
      .ref_sel  (cfg_rdata[1:0]),
      .src_tick (src_tick),
      .ref_tick (ref_tick)
   );

   lcd_ft_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (lcd_on),
      .ref_tick    (ref_tick),
      .duty_sel    (duty_sel),
      .com_adv     (com_adv),
      .com_idx     (com_idx),
      .frame_start (frame_start)
   );

   assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_rdata));

endmodule

// File: tb/tb_lcd_frame_timer.sv
`timescale 1ns/1ps
module tb_lcd_frame_timer;

   localparam int SMIN = 2;
   localparam int RMIN = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_ce = 1'b0, slow_ce = 1'b0, cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       lcd_on = 1'b0, scan_on = 1'b0, bias_on = 1'b0;
   logic [1:0] duty_sel = '0;
   logic [7:0] cfg_rdata;
   logic       com_adv, frame_start, rate_err, wr_err;
   logic [1:0] com_idx;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   lcd_frame_timer #(
      .SRC_MIN_LOG2 (SMIN),
      .REF_MIN_LOG2 (RMIN),
      .LOW_HZ       (2048),
      .MAX_FRAME_HZ (128)
   ) dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int lines_of(input logic [1:0] d);
      return (d == 2'b00) ? 1 : (d == 2'b01) ? 3 : 4;
   endfunction

   function automatic bit rate_bad(input int k, input logic [1:0] d);
      return ((d == 2'b00) && k <= 1) || ((d == 2'b01) && k == 0);
   endfunction

   // behavioural model of the timing chain
   logic [7:0] m_cfg;
   logic       m_werr, m_adv, m_fs;
   int         m_c1, m_c2, m_idx;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg <= '0; m_werr <= 1'b0; m_adv <= 1'b0; m_fs <= 1'b0;
         m_c1 <= 0; m_c2 <= 0; m_idx <= 0;
      end else begin
         int s, r, st, rt, nl;
         if (cfg_we) begin
            if (lcd_on || scan_on || bias_on) m_werr <= 1'b1;
            else m_cfg <= {4'h0, cfg_wdata[3:0]};
         end
         if (!lcd_on) begin
            m_c1 <= 0; m_c2 <= 0; m_idx <= 0; m_adv <= 1'b0; m_fs <= 1'b0;
         end else begin
            s = int'(m_cfg[3:2]);
            r = int'(m_cfg[1:0]);
            st = 0;
            rt = 0;
            if (s == 0) st = int'(slow_ce);
            else if (main_ce) begin
               if ((m_c1 + 1) % (1 << (SMIN + s - 1)) == 0) st = 1;
               m_c1 <= m_c1 + 1;
            end
            if (st != 0) begin
               if ((m_c2 + 1) % (1 << (RMIN + r)) == 0) rt = 1;
               m_c2 <= m_c2 + 1;
            end
            nl = lines_of(duty_sel);
            m_adv <= (rt != 0);
            m_fs  <= (rt != 0) && (m_idx >= nl - 1);
            if (rt != 0) m_idx <= (m_idx >= nl - 1) ? 0 : m_idx + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6 com_adv", int'(com_adv), int'(m_adv));
         chk("R7 com_idx", int'(com_idx), m_idx);
         chk("R8 frame_start", int'(frame_start), int'(m_fs));
         chk("R2 cfg_rdata", int'(cfg_rdata), int'(m_cfg));
         chk("R3 wr_err", int'(wr_err), int'(m_werr));
      end
   end

   task automatic write_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_adv(output int n);
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         n++;
         if (com_adv) break;
      end
   endtask

   task automatic period_case(input logic [3:0] cfgv, input int exp);
      int n;
      main_ce = 1'b1; slow_ce = 1'b1; duty_sel = 2'b00;
      write_cfg({4'h0, cfgv});
      lcd_on = 1'b1;
      wait_adv(n);
      chk("R4 R5 first period", n, exp);
      chk("R8 static frame", int'(frame_start), 1);
      wait_adv(n);
      chk("R6 steady period", n, exp);
      repeat (exp / 2) @(negedge clk);
      lcd_on = 1'b0;
      @(negedge clk);
      chk("R9 idle idx", int'(com_idx), 0);
      chk("R9 idle adv", int'(com_adv), 0);
      lcd_on = 1'b1;
      wait_adv(n);
      chk("R9 full first period", n, exp);
      lcd_on = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 cfg", int'(cfg_rdata), 0);
      chk("R1 adv", int'(com_adv), 0);
      chk("R1 idx", int'(com_idx), 0);
      chk("R1 frame", int'(frame_start), 0);
      chk("R1 werr", int'(wr_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: upper bits read zero
      write_cfg(8'hF6);
      chk("R2 stored", int'(cfg_rdata), 8'h06);
      // R3: blocked write, sticky flag
      scan_on = 1'b1;
      write_cfg(8'h03);
      scan_on = 1'b0;
      chk("R3 kept", int'(cfg_rdata), 8'h06);
      chk("R3 flag", int'(wr_err), 1);
      bias_on = 1'b1;
      write_cfg(8'h01);
      bias_on = 1'b0;
      chk("R3 kept bias", int'(cfg_rdata), 8'h06);
      write_cfg(8'h00);
      chk("R3 sticky", int'(wr_err), 1);

      // R10: rate limit table
      for (int d = 0; d < 4; d++) begin
         for (int k = 0; k < 4; k++) begin
            duty_sel = 2'(d);
            write_cfg(8'(k));
            #1;
            chk("R10 rate_err", int'(rate_err), int'(rate_bad(k, 2'(d))));
         end
      end

      // R4 R5 R6 R9 directed periods
      period_case(4'b0000, 1 << RMIN);
      period_case(4'b0001, 1 << (RMIN + 1));
      period_case(4'b0100, (1 << SMIN) * (1 << RMIN));
      period_case(4'b1000, (1 << (SMIN + 1)) * (1 << RMIN));
      period_case(4'b1111, (1 << (SMIN + 2)) * (1 << (RMIN + 3)));
      period_case(4'b1010, (1 << (SMIN + 1)) * (1 << (RMIN + 2)));

      // random phase checked by the model (R6 R7 R8 R3)
      for (int round = 0; round < 10; round++) begin
         lcd_on = 1'b0; scan_on = 1'b0; bias_on = 1'b0;
         duty_sel = 2'($urandom % 4);
         write_cfg(8'($urandom));
         lcd_on = 1'b1;
         for (int c = 0; c < 2500; c++) begin
            @(negedge clk);
            main_ce   = ($urandom % 4) != 0;
            slow_ce   = ($urandom % 3) == 0;
            cfg_we    = ($urandom % 60) == 0;
            cfg_wdata = 8'($urandom);
            scan_on   = ($urandom % 8) == 0;
            bias_on   = ($urandom % 8) == 0;
            if (($urandom % 500) == 0) lcd_on = ~lcd_on;
            else if (!lcd_on && ($urandom % 20) == 0) lcd_on = 1'b1;
         end
         cfg_we = 1'b0;
         @(negedge clk);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule